// File: doc/BRIEF.md
# I2C Target with Memory-Mapped Output Pins

This block is a write-mostly I2C target that keeps a 256-byte register map in flip-flops. A few of its locations are wired to general-purpose output pins. It takes the raw SCL and SDA lines and a mode strap, and returns an open-drain pull-down enable for SDA and the output-pin vector. A master addresses the target, sends a pointer byte and then streams data bytes into consecutive locations. A read transfer returns bytes from the current pointer.

Two output mappings are available. In shared mode, ordinary writes reach the map as plain storage. A dedicated output access then drives every pin at once from one data byte, so one pin can toggle on every byte (one toggle per 9 SCL periods). In per-pin mode, each pin owns one map location, so cycling all pins costs four bytes (one toggle per 36 SCL periods). In both modes, a pin only changes after the SCL pulse of the acknowledge slot that ends a write to an output location. After that pulse, a programmable settling delay runs before the pin moves.

A dedicated output access is selected by bit 1 of the address byte. The byte that follows it gives the output index, and the data bytes after that go straight to the pins.

Top module: `i2c_pio_target`

## Requirements
- R1: After reset, sda_pull is 0, every output pin is 0 and every map location reads 00h.
- R2: The address byte is {TARGET_ID[5:0], direct bit, R/W bit}. The target acknowledges only when bits 7:2 equal TARGET_ID. On a mismatch it leaves SDA released, ignores the rest of the transfer and waits for the next START. SDA is pulled or released only while SCL is low, and the target releases it after a START.
- R3: In a write transfer, the byte after the address sets the pointer. Each acknowledged data byte is stored at the pointer, and then the pointer advances by one, wrapping from FFh to 00h.
- R4: In per-pin mode (mode_single = 0), a plain write to location 7Ch+k stores the byte and sets pin k to bit 0 of that byte. The other pins keep their values.
- R5: In per-pin mode, writes to 78h and 79h are acknowledged but change nothing, and reads of them return 00h. Location 7Ah is ordinary storage.
- R6: In shared mode (mode_single = 1), plain writes store into any location 00h to FFh, including 78h to 7Fh, and never change the pins.
- R7: A direct access (address bit 1 = 1) works differently per mode. In shared mode, each data byte drives all pins from its low bits. In per-pin mode, each data byte sets pin (pointer mod 4) from bit 0, and the pointer advances.
- R8: A pin update is launched on the rising SCL edge of the acknowledge slot, never earlier. The pin then takes its new value PIO_DELAY system clocks after that update is loaded.
- R9: A STOP in the middle of a byte discards the partial byte. Memory and pins keep what the last acknowledged byte left.
- R10: In a read, the target shifts out the byte at the pointer MSB first and then advances the pointer. It continues while the master acknowledges and goes idle after a not-acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level, wired-AND of all drivers |
| mode_single | input | 1 | 1: shared output mapping, 0: per-pin output mapping |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| pio_out | output | NUM_PIO | Output pin levels |

## Verification
The assertions assume the master moves SDA only while SCL is low, except for START and STOP. They also assume the master never issues START or STOP while the target holds SDA low, and that each SCL phase lasts several system clocks so the target can react after SCL falls. The stimulus keeps an SCL phase of eight system clocks. It changes SDA two clocks after SCL falls, and it only issues STOP or repeated START after an acknowledge slot has ended or after a not-acknowledge. The stimulus covers the address space, a full pointer wrap in both directions of transfer, and writes that are aborted part-way through a byte.

// File: rtl/i2c_pio_pkg.sv
package i2c_pio_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] RSV_BASE = 8'h78;
  localparam logic [BYTE_W-1:0] PIO_BASE = 8'h7C;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } eng_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_in};
      sda_sh <= {sda_sh[STAGES-2:0], sda_in};
      scl_p  <= scl_sh[STAGES-1];
      sda_p  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  // SDA edges while SCL stays high mark bus conditions
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_pio_pkg::*;
#(
  parameter logic [5:0] TARGET_ID = 6'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              sda_pull,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_direct,
  output logic [BYTE_W-1:0] ptr,
  output logic              idle
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  eng_state_t        st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n, ptr_q, ptr_n;
  logic              pull_q, pull_n, rd_q, rd_n, dir_q, dir_n, mack_q, mack_n;

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    sh_n   = sh_q;
    ptr_n  = ptr_q;
    pull_n = pull_q;
    rd_n   = rd_q;
    dir_n  = dir_q;
    mack_n = mack_q;
    wr_en  = 1'b0;
    if (stop_det) begin
      st_n   = ST_IDLE;
      pull_n = 1'b0;
    end else if (start_det) begin
      st_n   = ST_ADDR;
      cnt_n  = '0;
      pull_n = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: ;
        ST_ADDR: begin
          if (scl_rise) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == LAST_BIT) begin
            if (sh_q[7:2] == TARGET_ID) begin
              st_n   = ST_ADDR_ACK;
              pull_n = 1'b1;
              rd_n   = sh_q[0];
              dir_n  = sh_q[1];
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (rd_q) begin
              st_n   = ST_RD;
              sh_n   = rd_byte;
              pull_n = ~rd_byte[BYTE_W-1];
            end else begin
              st_n   = ST_PTR;
              pull_n = 1'b0;
            end
          end
        end
        ST_PTR, ST_WR: begin
          if (scl_rise) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == LAST_BIT) begin
            st_n   = (st_q == ST_PTR) ? ST_PTR_ACK : ST_WR_ACK;
            pull_n = 1'b1;
          end
        end
        ST_PTR_ACK: begin
          if (scl_rise) ptr_n = sh_q;
          else if (scl_fall) begin
            st_n   = ST_WR;
            cnt_n  = '0;
            pull_n = 1'b0;
          end
        end
        ST_WR_ACK: begin
          if (scl_rise) begin
            wr_en = 1'b1;
            ptr_n = ptr_q + 1'b1;
          end else if (scl_fall) begin
            st_n   = ST_WR;
            cnt_n  = '0;
            pull_n = 1'b0;
          end
        end
        ST_RD: begin
          if (scl_rise) cnt_n = cnt_q + 1'b1;
          else if (scl_fall) begin
            if (cnt_q == LAST_BIT) begin
              st_n   = ST_RD_ACK;
              pull_n = 1'b0;
            end else begin
              sh_n   = {sh_q[BYTE_W-2:0], 1'b0};
              pull_n = ~sh_q[BYTE_W-2];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            mack_n = ~sda_s;
            ptr_n  = ptr_q + 1'b1;
          end else if (scl_fall) begin
            if (mack_q) begin
              st_n   = ST_RD;
              cnt_n  = '0;
              sh_n   = rd_byte;
              pull_n = ~rd_byte[BYTE_W-1];
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      ptr_q  <= '0;
      pull_q <= 1'b0;
      rd_q   <= 1'b0;
      dir_q  <= 1'b0;
      mack_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      ptr_q  <= ptr_n;
      pull_q <= pull_n;
      rd_q   <= rd_n;
      dir_q  <= dir_n;
      mack_q <= mack_n;
    end
  end

  assign sda_pull  = pull_q;
  assign wr_data   = sh_q;
  assign wr_direct = dir_q;
  assign ptr       = ptr_q;
  assign idle      = (st_q == ST_IDLE);
endmodule

// File: rtl/i2c_pio_regmap.sv
module i2c_pio_regmap
  import i2c_pio_pkg::*;
#(
  parameter int unsigned NUM_PIO = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_single,
  input  logic               wr_en,
  input  logic [BYTE_W-1:0]  wr_data,
  input  logic               wr_direct,
  input  logic [BYTE_W-1:0]  ptr,
  output logic [BYTE_W-1:0]  rd_byte,
  output logic               pio_load,
  output logic [NUM_PIO-1:0] pio_next
);
  localparam int unsigned DEPTH  = 1 << BYTE_W;
  localparam int unsigned PIDX_W = $clog2(NUM_PIO);
  localparam logic [BYTE_W-1-PIDX_W:0] PIO_TAG = PIO_BASE[BYTE_W-1:PIDX_W];

  logic [BYTE_W-1:0]  mem [DEPTH];
  logic [NUM_PIO-1:0] shadow_q;
  logic               mem_we;
  logic [BYTE_W-1:0]  mem_addr;
  logic [PIDX_W-1:0]  pidx;
  logic               at_rsv, at_pio;

  assign pidx   = ptr[PIDX_W-1:0];
  assign at_rsv = ~mode_single & (ptr[BYTE_W-1:1] == RSV_BASE[BYTE_W-1:1]);
  assign at_pio = ~mode_single & (ptr[BYTE_W-1:PIDX_W] == PIO_TAG);

  always_comb begin
    mem_we   = 1'b0;
    mem_addr = ptr;
    pio_load = 1'b0;
    pio_next = shadow_q;
    if (wr_en) begin
      if (wr_direct) begin
        pio_load = 1'b1;
        if (mode_single) begin
          pio_next = wr_data[NUM_PIO-1:0];
        end else begin
          mem_we         = 1'b1;
          mem_addr       = {PIO_TAG, pidx};
          pio_next[pidx] = wr_data[0];
        end
      end else if (mode_single) begin
        mem_we = 1'b1;
      end else if (!at_rsv) begin
        mem_we = 1'b1;
        if (at_pio) begin
          pio_load       = 1'b1;
          pio_next[pidx] = wr_data[0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (mem_we) begin
      mem[mem_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        shadow_q <= '0;
    else if (pio_load) shadow_q <= pio_next;
  end

  assign rd_byte = at_rsv ? '0 : mem[ptr];
endmodule

// File: rtl/i2c_pio_drive.sv
module i2c_pio_drive #(
  parameter int unsigned NUM_PIO   = 4,
  parameter int unsigned PIO_DELAY = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [NUM_PIO-1:0] next,
  output logic [NUM_PIO-1:0] pio_out
);
  logic [NUM_PIO-1:0] out_q;

  generate
    if (PIO_DELAY == 0) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    out_q <= '0;
        else if (load) out_q <= next;
      end
    end else begin : g_delay
      localparam int unsigned CNT_W = $clog2(PIO_DELAY + 1);
      logic [CNT_W-1:0]   cnt_q, cnt_n;
      logic [NUM_PIO-1:0] pend_q, pend_n, out_n;

      always_comb begin
        cnt_n  = cnt_q;
        pend_n = pend_q;
        out_n  = out_q;
        if (load) begin
          cnt_n  = CNT_W'(PIO_DELAY);
          pend_n = next;
        end else if (cnt_q != '0) begin
          cnt_n = cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) out_n = pend_q;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q  <= '0;
          pend_q <= '0;
          out_q  <= '0;
        end else begin
          cnt_q  <= cnt_n;
          pend_q <= pend_n;
          out_q  <= out_n;
        end
      end
    end
  endgenerate

  assign pio_out = out_q;
endmodule

// File: rtl/i2c_pio_target.sv
module i2c_pio_target
  import i2c_pio_pkg::*;
#(
  parameter logic [5:0]  TARGET_ID   = 6'h28,
  parameter int unsigned NUM_PIO     = 4,
  parameter int unsigned PIO_DELAY   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  input  logic               mode_single,
  output logic               sda_pull,
  output logic [NUM_PIO-1:0] pio_out
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en, wr_direct, idle, pio_load;
  logic [BYTE_W-1:0]  wr_data, ptr, rd_byte;
  logic [NUM_PIO-1:0] pio_next;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_target_fsm #(.TARGET_ID(TARGET_ID)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_byte(rd_byte), .sda_pull(sda_pull), .wr_en(wr_en), .wr_data(wr_data),
    .wr_direct(wr_direct), .ptr(ptr), .idle(idle)
  );

  i2c_pio_regmap #(.NUM_PIO(NUM_PIO)) u_map (
    .clk(clk), .rst_n(rst_n), .mode_single(mode_single), .wr_en(wr_en),
    .wr_data(wr_data), .wr_direct(wr_direct), .ptr(ptr), .rd_byte(rd_byte),
    .pio_load(pio_load), .pio_next(pio_next)
  );

  i2c_pio_drive #(.NUM_PIO(NUM_PIO), .PIO_DELAY(PIO_DELAY)) u_drive (
    .clk(clk), .rst_n(rst_n), .load(pio_load), .next(pio_next), .pio_out(pio_out)
  );
endmodule

// File: rtl/i2c_pio_chk.sv
module i2c_pio_chk #(
  parameter int unsigned NUM_PIO   = 4,
  parameter int unsigned PIO_DELAY = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_s,
  input logic               start_det,
  input logic               sda_pull,
  input logic               idle,
  input logic               pio_load,
  input logic [NUM_PIO-1:0] pio_out
);
  assert_pull_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_s);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_pull);

  assert_start_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_pull);

  assert_load_on_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pio_load |-> scl_s);

  generate
    if (PIO_DELAY > 0) begin : g_hold
      assert_hold_after_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pio_load |=> $stable(pio_out));
    end
  endgenerate
endmodule

bind i2c_pio_target i2c_pio_chk #(.NUM_PIO(NUM_PIO), .PIO_DELAY(PIO_DELAY)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
  .sda_pull(sda_pull), .idle(idle), .pio_load(pio_load), .pio_out(pio_out)
);

// File: tb/sim_i2c_pio_target.sv
module sim_i2c_pio_target;
  localparam logic [5:0] ID = 6'h28;
  localparam int HP = 8;

  logic clk, rst_n, scl_m, sda_m, mode_single;
  logic       sda_pull;
  logic [3:0] pio_out;
  wire        sda_line = sda_m & ~sda_pull;

  int total = 0;
  int bad = 0;
  logic [7:0] model [256];

  i2c_pio_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .mode_single(mode_single), .sda_pull(sda_pull), .pio_out(pio_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    tick(2); sda_m = 1'b1; tick(HP); scl_m = 1'b1; tick(HP);
    sda_m = 1'b0; tick(HP); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    tick(2); sda_m = 1'b0; tick(HP); scl_m = 1'b1; tick(HP);
    sda_m = 1'b1; tick(HP);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      tick(2); sda_m = b[i]; tick(HP - 2); scl_m = 1'b1; tick(HP); scl_m = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    send_bits(b, 8);
    tick(2); sda_m = 1'b1; tick(HP - 2); scl_m = 1'b1;
    tick(HP / 2); acked = ~sda_line; tick(HP / 2); scl_m = 1'b0;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(HP); scl_m = 1'b1; tick(HP / 2); b[i] = sda_line; tick(HP / 2); scl_m = 1'b0;
    end
    tick(2); sda_m = ~give_ack; tick(HP - 2); scl_m = 1'b1; tick(HP); scl_m = 1'b0;
    tick(2); sda_m = 1'b1;
  endtask

  task automatic set_ptr(input logic direct, input logic [7:0] p);
    logic a;
    bus_start();
    send_byte({ID, direct, 1'b0}, a);
    send_byte(p, a);
  endtask

  task automatic read_cmp(input logic [7:0] p, input int n, input string tag);
    logic a;
    logic [7:0] b;
    set_ptr(1'b0, p);
    bus_start();
    send_byte({ID, 2'b01}, a);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      check(tag, b, model[8'(p + i)]);
    end
    bus_stop();
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 8'hFF);
  endfunction

  initial begin
    repeat (195000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] b;
    int nak;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; mode_single = 1'b1;
    tick(5); rst_n = 1'b1; tick(3);

    // R1 reset state
    check("R1 sda_pull", sda_pull, 0);
    check("R1 pio_out", pio_out, 0);
    read_cmp(8'h40, 2, "R1 reset memory");

    // R2 address decode sweep over bits 7:2
    for (int hi = 0; hi < 64; hi++) begin
      bus_start();
      send_byte({6'(hi), 2'b00}, a);
      check("R2 address ack", a, (6'(hi) == ID));
      if (6'(hi) != ID) begin
        send_byte(8'h33, a);
        check("R2 ignored after mismatch", a, 0);
      end
      bus_stop();
    end

    // R3 / R6 full write sweep with pointer wrap, shared mode
    set_ptr(1'b0, 8'h00);
    nak = 0;
    for (int i = 0; i < 256; i++) begin
      send_byte(pat(i), a);
      if (!a) nak++;
      model[i] = pat(i);
    end
    send_byte(8'h5A, a);
    if (!a) nak++;
    model[0] = 8'h5A;
    bus_stop();
    check("R3 data acks", nak, 0);
    check("R6 pins untouched by plain writes", pio_out, 0);
    read_cmp(8'h00, 256, "R3 readback after wrap");

    // R10 read pointer continues after NACK-terminated read
    read_cmp(8'h30, 2, "R10 read");
    bus_start();
    send_byte({ID, 2'b01}, a);
    recv_byte(1'b0, b);
    bus_stop();
    check("R10 pointer advanced by reads", b, model[8'h32]);

    // R5 reserved locations in per-pin mode
    mode_single = 1'b0;
    set_ptr(1'b0, 8'h78);
    bus_start();
    send_byte({ID, 2'b01}, a);
    recv_byte(1'b1, b); check("R5 read 78h", b, 0);
    recv_byte(1'b0, b); check("R5 read 79h", b, 0);
    bus_stop();
    set_ptr(1'b0, 8'h78);
    send_byte(8'h11, a); check("R5 ack at 78h", a, 1);
    send_byte(8'h22, a); check("R5 ack at 79h", a, 1);
    send_byte(8'h33, a); model[8'h7A] = 8'h33;
    bus_stop();
    check("R5 pins untouched", pio_out, 0);
    mode_single = 1'b1;
    read_cmp(8'h78, 3, "R5 reserved write had no effect");

    // R4 per-pin writes to 7Ch..7Fh
    mode_single = 1'b0;
    set_ptr(1'b0, 8'h7C);
    send_byte(8'h01, a); tick(HP); check("R4 pin0", pio_out, 4'b0001);
    send_byte(8'h00, a); tick(HP); check("R4 pin1", pio_out, 4'b0001);
    send_byte(8'hFF, a); tick(HP); check("R4 pin2", pio_out, 4'b0101);
    send_byte(8'h01, a); tick(HP); check("R4 pin3", pio_out, 4'b1101);
    bus_stop();
    model[8'h7C] = 8'h01; model[8'h7D] = 8'h00; model[8'h7E] = 8'hFF; model[8'h7F] = 8'h01;
    read_cmp(8'h7C, 4, "R4 stored pin bytes");

    // R8 launch point: pin 1 written with 1
    set_ptr(1'b0, 8'h7D);
    send_bits(8'h01, 8);
    tick(2); sda_m = 1'b1; tick(HP - 2);
    check("R8 unchanged before ack clock", pio_out, 4'b1101);
    scl_m = 1'b1; tick(2);
    check("R8 unchanged at ack rise", pio_out, 4'b1101);
    tick(HP - 2); scl_m = 1'b0; tick(HP);
    check("R8 changed after ack clock", pio_out, 4'b1111);
    bus_stop();

    // R7 direct access, shared mode then per-pin mode
    mode_single = 1'b1;
    set_ptr(1'b1, 8'h00);
    send_byte(8'h0A, a); tick(HP); check("R7 shared direct 0A", pio_out, 4'b1010);
    send_byte(8'h05, a); tick(HP); check("R7 shared direct 05", pio_out, 4'b0101);
    bus_stop();
    read_cmp(8'h00, 1, "R7 direct left memory alone");
    mode_single = 1'b0;
    set_ptr(1'b1, 8'h02);
    send_byte(8'h00, a); tick(HP); check("R7 per-pin direct idx2", pio_out, 4'b0001);
    send_byte(8'h01, a); tick(HP); check("R7 per-pin direct idx3", pio_out, 4'b1001);
    bus_stop();

    // R9 STOP inside a byte
    mode_single = 1'b1;
    set_ptr(1'b1, 8'h00);
    send_byte(8'h0F, a); tick(HP); check("R9 full byte applied", pio_out, 4'b1111);
    send_bits(8'h00, 4);
    bus_stop(); tick(HP);
    check("R9 partial byte discarded (pins)", pio_out, 4'b1111);
    set_ptr(1'b0, 8'h20);
    send_byte(8'hAA, a); model[8'h20] = 8'hAA;
    send_bits(8'h55, 5);
    bus_stop();
    read_cmp(8'h20, 2, "R9 partial byte discarded (memory)");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule